// File: doc/BRIEF.md
# Serial Interrupt Host Controller

This block is the host end of a single-wire, shared serial interrupt line. It opens each bus cycle with a low start pulse. The first cycle after reset starts on its own. After that it either re-arms at the end of every stop frame (continuous mode) or waits idle until a peripheral pulls the line low for one clock (quiet mode). Once the start pulse ends, it walks through sixteen three-clock data frames. On each frame's sample clock it captures the line level into a level vector, where a low line means the interrupt is asserted.

The cycle closes with a stop pulse. Its width tells every agent on the line which mode the next cycle uses. The host drives the line through a value and enable pair and reads it back through a separate input. The low width of the start pulse comes from a small setting. The mode for the next cycle is sampled from a select input at the start of each stop frame.

Top module: `sirq_host_ctrl`

## Requirements
- R1: While reset is held and in the first clock after it is released, the line is not driven (`line_oe_o`=0) and the level vector is all zero. The controller leaves reset in continuous mode and drives the first start pulse from the next clock.
- R2: A start pulse opened by the host (continuous mode) holds the line low for W+1 clocks. W is `start_width_i` sampled as the pulse begins, and values 0 to 2 are treated as 3, so the low time is 4 to 8 clocks.
- R3: In quiet-mode idle, one clock with `line_i`=0 makes the host drive the line low from the next clock onward, for W clocks (W as in R2).
- R4: Every host-driven low pulse is followed by exactly one clock with the line driven high, and the clock after that the line is released.
- R5: The clock with the start pulse driven high is clock 0. Frame k (k=1..16) is sampled on clock 3k-1, and for k=2..16 bit k-1 of `irq_vec_o` takes the inverse of `line_i`. The new value appears on the next clock, and the line is released throughout clocks 1 to 49.
- R6: Frame 1 is unused, so bit 0 of `irq_vec_o` stays 0.
- R7: The stop pulse starts on clock 50. It is low for 2 clocks when `mode_quiet_i`=1 on clock 49, otherwise for 3 clocks. Then comes one high clock and one released clock.
- R8: The mode is taken from `mode_quiet_i` only on clock 49. After the released clock that ends a stop frame, continuous mode opens a new start pulse at once, and quiet mode leaves the line released and idle.
- R9: Outside quiet-mode idle, a low `line_i` starts no cycle. This covers any non-sample clock of the frames and the released clock that ends the stop frame.
- R10: Vector bits keep their value between cycles, including through idle time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_quiet_i | input | 1 | Next-cycle mode select, 1 = quiet, 0 = continuous |
| start_width_i | input | 3 | Start low width setting W (3..7, lower values clamp to 3) |
| line_i | input | 1 | Sampled level of the serial line |
| line_o | output | 1 | Value driven onto the line |
| line_oe_o | output | 1 | Drive enable for the line |
| irq_vec_o | output | 16 | Interrupt level vector, bit k-1 from frame k |

## Verification
Two things can land on the same clock. A peripheral's start request can coincide with a cycle already in flight, and a mode-select change can coincide with the end of the data frames. The bench pulls `line_i` low on frame recovery clocks and on the released clock that ends a quiet stop frame, then expects the next scheduled line activity with no early start pulse. It also flips `mode_quiet_i` on every clock except clock 49, and it judges the stop pulse width and the following idle or restart only by the value held on that clock.

// File: rtl/sirq_host_pkg.sv
package sirq_host_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_START,
        SEQ_START_HI,
        SEQ_FRAMES,
        SEQ_STOP,
        SEQ_STOP_HI,
        SEQ_REST
    } seq_state_e;

    localparam logic [1:0] PH_SAMPLE = 2'd1;
    localparam logic [1:0] PH_LAST   = 2'd2;

endpackage

// File: rtl/sirq_width_sel.sv
module sirq_width_sel #(
    parameter int WIDTH_MIN = 3,
    parameter int WIDTH_MAX = 7,
    parameter int CNT_W     = 4,
    localparam int SW_W     = $clog2(WIDTH_MAX + 1)
) (
    input  logic [SW_W-1:0]  width_i,
    output logic [CNT_W-1:0] load_host_o,
    output logic [CNT_W-1:0] load_req_o
);

    localparam logic [SW_W-1:0] MIN_V = SW_W'(WIDTH_MIN);

    logic [SW_W-1:0] eff;

    always_comb begin
        eff         = (width_i < MIN_V) ? MIN_V : width_i;
        // host-opened pulse lasts eff+1 clocks, counter loads length-1
        load_host_o = CNT_W'(eff);
        // request-opened pulse: the peripheral already gave one low clock
        load_req_o  = CNT_W'(eff) - CNT_W'(1);
    end

endmodule

// File: rtl/sirq_level_sampler.sv
module sirq_level_sampler #(
    parameter int NUM_FRAMES = 16,
    parameter int IDX_W      = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sample_en_i,
    input  logic [IDX_W-1:0]      frame_idx_i,
    input  logic                  line_i,
    output logic [NUM_FRAMES-1:0] vec_o
);

    logic [NUM_FRAMES-1:0] vec_d, vec_q;

    always_comb begin
        vec_d = vec_q;
        if (sample_en_i) begin
            // frame 1 carries nothing, frame k lands in bit k-1
            for (int i = 1; i < NUM_FRAMES; i++) begin
                if (frame_idx_i == IDX_W'(i + 1)) begin
                    vec_d[i] = ~line_i;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else begin
            vec_q <= vec_d;
        end
    end

    assign vec_o = vec_q;

endmodule

// File: rtl/sirq_seq_fsm.sv
module sirq_seq_fsm
    import sirq_host_pkg::*;
#(
    parameter int NUM_FRAMES = 16,
    parameter int CNT_W      = 4,
    parameter int IDX_W      = 5,
    parameter int STOP_QUIET = 2,
    parameter int STOP_CONT  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_quiet_i,
    input  logic             line_i,
    input  logic [CNT_W-1:0] load_host_i,
    input  logic [CNT_W-1:0] load_req_i,
    output logic             line_o,
    output logic             line_oe_o,
    output logic             sample_en_o,
    output logic [IDX_W-1:0] frame_idx_o
);

    localparam int LAST_TICK = 3 * NUM_FRAMES + 1;
    localparam int TICK_W    = $clog2(LAST_TICK + 1);

    typedef struct packed {
        seq_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [TICK_W-1:0] tick;
        logic [1:0]        phase;
        logic [IDX_W-1:0]  frame;
        logic              quiet;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;
    logic      sample_en;

    always_comb begin
        seq_d     = seq_q;
        sample_en = 1'b0;
        unique case (seq_q.state)
            SEQ_IDLE: begin
                if (!line_i) begin
                    seq_d.state = SEQ_START;
                    seq_d.cnt   = load_req_i;
                end
            end
            SEQ_START: begin
                if (seq_q.cnt == '0) begin
                    seq_d.state = SEQ_START_HI;
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            SEQ_START_HI: begin
                seq_d.state = SEQ_FRAMES;
                seq_d.tick  = TICK_W'(1);
                seq_d.phase = 2'd0;
                seq_d.frame = IDX_W'(1);
            end
            SEQ_FRAMES: begin
                if (seq_q.phase == PH_SAMPLE) begin
                    sample_en   = 1'b1;
                    seq_d.frame = seq_q.frame + IDX_W'(1);
                end
                seq_d.phase = (seq_q.phase == PH_LAST) ? 2'd0 : seq_q.phase + 2'd1;
                if (seq_q.tick == TICK_W'(LAST_TICK)) begin
                    seq_d.state = SEQ_STOP;
                    seq_d.quiet = mode_quiet_i;
                    seq_d.cnt   = mode_quiet_i ? CNT_W'(STOP_QUIET - 1)
                                               : CNT_W'(STOP_CONT - 1);
                end else begin
                    seq_d.tick = seq_q.tick + TICK_W'(1);
                end
            end
            SEQ_STOP: begin
                if (seq_q.cnt == '0) begin
                    seq_d.state = SEQ_STOP_HI;
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            SEQ_STOP_HI: begin
                seq_d.state = SEQ_REST;
            end
            SEQ_REST: begin
                if (seq_q.quiet) begin
                    seq_d.state = SEQ_IDLE;
                end else begin
                    seq_d.state = SEQ_START;
                    seq_d.cnt   = load_host_i;
                end
            end
            default: begin
                seq_d.state = SEQ_REST;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{state: SEQ_REST, cnt: '0, tick: '0,
                       phase: 2'd0, frame: '0, quiet: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        line_oe_o = (seq_q.state == SEQ_START)    || (seq_q.state == SEQ_STOP) ||
                    (seq_q.state == SEQ_START_HI) || (seq_q.state == SEQ_STOP_HI);
        line_o    = !((seq_q.state == SEQ_START) || (seq_q.state == SEQ_STOP));
    end

    assign sample_en_o = sample_en;
    assign frame_idx_o = seq_q.frame;

endmodule

// File: rtl/sirq_host_ctrl.sv
module sirq_host_ctrl #(
    parameter int NUM_FRAMES = 16,
    parameter int WIDTH_MIN  = 3,
    parameter int WIDTH_MAX  = 7,
    parameter int STOP_QUIET = 2,
    parameter int STOP_CONT  = 3,
    localparam int SW_W      = $clog2(WIDTH_MAX + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_quiet_i,
    input  logic [SW_W-1:0]       start_width_i,
    input  logic                  line_i,
    output logic                  line_o,
    output logic                  line_oe_o,
    output logic [NUM_FRAMES-1:0] irq_vec_o
);

    localparam int CNT_W = $clog2(WIDTH_MAX + 2);
    localparam int IDX_W = $clog2(NUM_FRAMES + 2);

    logic [CNT_W-1:0] load_host, load_req;
    logic             sample_en;
    logic [IDX_W-1:0] frame_idx;

    sirq_width_sel #(
        .WIDTH_MIN (WIDTH_MIN),
        .WIDTH_MAX (WIDTH_MAX),
        .CNT_W     (CNT_W)
    ) u_width (
        .width_i     (start_width_i),
        .load_host_o (load_host),
        .load_req_o  (load_req)
    );

    sirq_seq_fsm #(
        .NUM_FRAMES (NUM_FRAMES),
        .CNT_W      (CNT_W),
        .IDX_W      (IDX_W),
        .STOP_QUIET (STOP_QUIET),
        .STOP_CONT  (STOP_CONT)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_quiet_i (mode_quiet_i),
        .line_i       (line_i),
        .load_host_i  (load_host),
        .load_req_i   (load_req),
        .line_o       (line_o),
        .line_oe_o    (line_oe_o),
        .sample_en_o  (sample_en),
        .frame_idx_o  (frame_idx)
    );

    sirq_level_sampler #(
        .NUM_FRAMES (NUM_FRAMES),
        .IDX_W      (IDX_W)
    ) u_levels (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_en_i (sample_en),
        .frame_idx_i (frame_idx),
        .line_i      (line_i),
        .vec_o       (irq_vec_o)
    );

endmodule

// File: rtl/sirq_host_checker.sv
module sirq_host_checker #(
    parameter int NUM_FRAMES = 16,
    parameter int WIDTH_MAX  = 7
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  line_o,
    input logic                  line_oe_o,
    input logic [NUM_FRAMES-1:0] irq_vec_o
);

    localparam int RUN_W  = $clog2(WIDTH_MAX + 3) + 1;
    localparam int MAX_LO = WIDTH_MAX + 1;

    logic [RUN_W-1:0] low_run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run_q <= '0;
        end else if (line_oe_o && !line_o) begin
            if (low_run_q != '1) low_run_q <= low_run_q + RUN_W'(1);
        end else begin
            low_run_q <= '0;
        end
    end

    // R2: a host low pulse never lasts more than WIDTH_MAX+1 clocks
    a_r2_low_max: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe_o && !line_o) |-> (low_run_q < RUN_W'(MAX_LO)));

    // R4: a driven-high clock is always followed by a released line
    a_r4_high_release: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe_o && line_o) |=> !line_oe_o);

    // R5: the vector only changes right after a clock with the line released
    a_r5_vec_released: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(irq_vec_o) |-> !$past(line_oe_o));

    // R6: the unused first frame never sets bit 0
    a_r6_bit0_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_vec_o[0]);

endmodule

bind sirq_host_ctrl sirq_host_checker #(
    .NUM_FRAMES (NUM_FRAMES),
    .WIDTH_MAX  (WIDTH_MAX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_o    (line_o),
    .line_oe_o (line_oe_o),
    .irq_vec_o (irq_vec_o)
);

// File: tb/sirq_host_ctrl_tb.sv
module sirq_host_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NF         = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          mode_quiet_i;
    logic [2:0]    start_width_i;
    logic          line_i;
    logic          line_o;
    logic          line_oe_o;
    logic [NF-1:0] irq_vec_o;

    typedef struct {
        logic          oe;
        logic          o;
        logic          care_o;
        logic [NF-1:0] vec;
        string         tag;
        string         vtag;
    } exp_t;

    exp_t          sb_q[$];
    logic [NF-1:0] model_vec;
    int            n_checks = 0;
    int            n_fails  = 0;
    bit            done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sirq_host_ctrl u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_quiet_i  (mode_quiet_i),
        .start_width_i (start_width_i),
        .line_i        (line_i),
        .line_o        (line_o),
        .line_oe_o     (line_oe_o),
        .irq_vec_o     (irq_vec_o)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic push(input logic oe, input logic o, input logic care, input string tag,
                        input string vtag);
        exp_t e;
        e.oe = oe; e.o = o; e.care_o = care; e.vec = model_vec; e.tag = tag; e.vtag = vtag;
        sb_q.push_back(e);
    endtask

    // monitor: compares one expected item per clock, after the driver's negedge update
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                chk(line_oe_o === e.oe, {e.tag, " line_oe"}, line_oe_o, e.oe);
                if (e.care_o) chk(line_o === e.o, {e.tag, " line_o"}, line_o, e.o);
                chk(irq_vec_o === e.vec, {e.vtag, " irq_vec"}, irq_vec_o, e.vec);
                chk(irq_vec_o[0] === 1'b0, "R6 bit0", irq_vec_o[0], 0);
            end
        end
    end

    task automatic idle_cycles(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            line_i = 1'b1;
            push(1'b0, 1'b0, 1'b0, tag, "R10");
        end
    endtask

    // one complete bus cycle; from_req adds the peripheral's request clock
    task automatic bus_cycle(input int w_in, input bit from_req, input bit next_quiet,
                             input logic [NF-1:0] irqs, input bit glitch, input int next_w);
        int w_eff;
        int lo_len;
        w_eff  = (w_in < 3) ? 3 : w_in;
        lo_len = from_req ? w_eff : w_eff + 1;
        if (from_req) begin
            @(negedge clk);
            line_i        = 1'b0;          // R3 request
            start_width_i = 3'(w_in);
            push(1'b0, 1'b0, 1'b0, "R3 request", "R10");
        end
        for (int i = 0; i < lo_len; i++) begin
            @(negedge clk);
            line_i = 1'b1;
            push(1'b1, 1'b0, 1'b1, from_req ? "R3 start low" : "R2 start low", "R5");
        end
        @(negedge clk);
        push(1'b1, 1'b1, 1'b1, "R4 start high", "R5");
        for (int c = 1; c <= 3 * NF + 1; c++) begin
            int k;
            @(negedge clk);
            k = 0;
            line_i = 1'b1;
            if ((c % 3) == 2) begin
                k = (c + 1) / 3;
                line_i = ~irqs[k-1];
            end else if (glitch && (c % 3) == 0) begin
                line_i = 1'b0;                   // R9 ignored while active
            end
            mode_quiet_i = (c == 3 * NF + 1) ? next_quiet : ~next_quiet;   // R8
            push(1'b0, 1'b0, 1'b0, glitch ? "R9 frames" : "R5 frames", "R5");
            if (k >= 2) model_vec[k-1] = irqs[k-1];
        end
        for (int i = 0; i < (next_quiet ? 2 : 3); i++) begin
            @(negedge clk);
            line_i       = 1'b1;
            mode_quiet_i = ~next_quiet;
            push(1'b1, 1'b0, 1'b1, "R7 stop low", "R5");
        end
        @(negedge clk);
        push(1'b1, 1'b1, 1'b1, "R7 stop high", "R5");
        @(negedge clk);
        start_width_i = 3'(next_w);
        line_i        = (next_quiet && glitch) ? 1'b0 : 1'b1;     // R9 at rest clock
        push(1'b0, 1'b0, 1'b0, "R8 rest", "R5");
    endtask

    initial begin
        rst_n         = 1'b0;
        mode_quiet_i  = 1'b0;
        start_width_i = 3'd5;
        line_i        = 1'b1;
        model_vec     = '0;
        repeat (3) @(negedge clk);
        #1;
        chk(line_oe_o === 1'b0, "R1 reset oe", line_oe_o, 0);
        chk(irq_vec_o === '0, "R1 reset vec", irq_vec_o, 0);
        @(negedge clk);
        rst_n = 1'b1;
        push(1'b0, 1'b0, 1'b0, "R1 first clock", "R1");
        bus_cycle(5, 1'b0, 1'b0, 16'hA5A5, 1'b0, 0);
        bus_cycle(0, 1'b0, 1'b1, 16'h3C96, 1'b0, 7);
        idle_cycles(4, "R8 quiet idle");
        bus_cycle(7, 1'b1, 1'b1, 16'hFFFF, 1'b1, 3);
        idle_cycles(3, "R9 idle after glitch");
        bus_cycle(3, 1'b1, 1'b0, 16'h0001, 1'b0, 6);
        bus_cycle(6, 1'b0, 1'b0, 16'h8001, 1'b0, 6);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule